// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Boundary-Latched Updates

The block generates four independent pulse-width modulated outputs. Each channel has a period counter clocked through a power-of-two prescaler. It produces either a left-aligned or a center-aligned waveform, with a selectable active level. All configuration goes through a simple 32-bit register bus. A read returns its data on `rdata_o` one cycle after the request; a write takes effect at the clock edge that samples it.

Channels are started and stopped through two write-one bitmask registers, so any group of channels can start in the same cycle and stay phase-aligned. While a channel runs, software changes its duty or period through a per-channel staging register. The staged value is committed only when the current period ends, so no pulse is ever cut short or stretched. Every period end sets a per-channel interrupt flag. A mask register decides which flags drive the interrupt line.

Register map (byte offsets):
- Global block: 0x04 start, 0x08 stop, 0x0C running status, 0x10 mask set, 0x14 mask clear, 0x18 mask, 0x1C flags. Offset 0x00 is reserved: it reads 0 and ignores writes.
- Channel n window at 0x200 + 0x20·n: +0x0 mode, +0x4 duty, +0x8 period, +0xC counter (read-only), +0x10 staging (write-only, reads 0).

Top module: `pwm_ctrl`

## Requirements
- R1: Writing 0x04 with bit n set starts channel n; bits written as 0 leave their channel unchanged, so one write can start several channels at once.
- R2: Writing 0x08 with bit n set stops channel n; its counter returns to 0 and its output goes to the inactive level, while other channels are unaffected.
- R3: Reading 0x0C returns bit n = 1 exactly while channel n runs; read data appears on `rdata_o` the cycle after the request.
- R4: Mode bits 3:0 select a prescale p; the channel counter advances once every 2^p input clocks (values above 10 act as 10).
- R5: With mode bit 8 = 0 (left-aligned), the counter runs 0 to period−1 and wraps, and the output is active while counter < duty, giving min(duty, period)·2^p active clocks per period·2^p clocks.
- R6: With mode bit 8 = 1 (center-aligned), the counter climbs to the period and falls back to 0, lasting 2·period ticks, with the output active while counter < duty (2·duty−1 active ticks for 1 ≤ duty ≤ period).
- R7: Mode bit 9 = 0 makes the active level high, and bit 9 = 1 makes it low; a stopped channel drives the inactive level (low after reset).
- R8: A staging write to +0x10 on a running channel is committed at the next period end, into duty if mode bit 10 = 0 or into period if it is 1; the target register keeps its old value until then.
- R9: A staging write on a stopped channel is committed at once to the target selected by mode bit 10.
- R10: Duty, period and counter are 16 bits; upper write bits are dropped, and the mode register reads back only bits 10:8 and 3:0.
- R11: Each period end sets flag bit n at 0x1C, whatever the mask; `irq_o` is high while any flag bit has its mask bit set.
- R12: Writing 0x10 sets, and writing 0x14 clears, the mask bits written as 1; the mask reads back at 0x18 and is 0 after reset.
- R13: Reading 0x1C returns the flags and clears them, except a period end in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| pwm_o | output | 4 | One modulated output per channel |
| irq_o | output | 1 | Interrupt, high while an unmasked flag is set |

## Verification
The properties check bus-visible state on every cycle:
- start and stop writes reach the run bits on the next edge;
- the status read returns the run vector;
- a stopped channel's counter is zero;
- flags rise only after a period end, and a flag read clears them;
- a running channel's duty changes only after a period end or a direct write.

Waveform shape needs the bench's scenarios. That covers active-clock counts per window for both alignments, prescale and polarity. It also covers the commit point of staged values for both targets and the interplay of mask and flags.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [4:0] G_START = 5'h04;
  localparam logic [4:0] G_STOP  = 5'h08;
  localparam logic [4:0] G_STAT  = 5'h0C;
  localparam logic [4:0] G_MSET  = 5'h10;
  localparam logic [4:0] G_MCLR  = 5'h14;
  localparam logic [4:0] G_MASK  = 5'h18;
  localparam logic [4:0] G_FLAG  = 5'h1C;

  localparam logic [4:0] C_MODE  = 5'h00;
  localparam logic [4:0] C_DUTY  = 5'h04;
  localparam logic [4:0] C_PER   = 5'h08;
  localparam logic [4:0] C_CNT   = 5'h0C;
  localparam logic [4:0] C_STAGE = 5'h10;

  localparam int unsigned PRE_W   = 4;
  localparam int unsigned PRE_MAX = 10;

  typedef struct packed {
    logic                 stage_per;  // staging target: 1 period, 0 duty
    logic                 act_low;
    logic                 center;
    logic [PRE_W-1:0]     pre;
  } ch_mode_t;
endpackage

// File: rtl/pwm_presc.sv
module pwm_presc
  import pwm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_MAX-1:0] pc_q;
  logic [PRE_W-1:0]   eff;
  logic [PRE_MAX:0]   one_sh;
  logic [PRE_MAX-1:0] lim;

  assign eff    = (sel_i > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : sel_i;
  assign one_sh = (PRE_MAX+1)'(1) << eff;
  assign lim    = PRE_MAX'(one_sh - 1'b1);
  assign tick_o = en_i && (pc_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (!en_i)   pc_q <= '0;
    else if (tick_o)  pc_q <= '0;
    else              pc_q <= pc_q + 1'b1;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          mode_we_i,
  input  ch_mode_t      mode_i,
  input  logic          duty_we_i,
  input  logic          per_we_i,
  input  logic          stage_we_i,
  input  logic [CW-1:0] wdata_i,
  output ch_mode_t      mode_o,
  output logic [CW-1:0] duty_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] cnt_o,
  output logic          evt_o,
  output logic          pwm_o
);
  ch_mode_t      mode_q;
  logic [CW-1:0] duty_q, per_q, cnt_q, stage_q;
  logic          pend_q, pend_per_q, dn_q;
  logic          tick;
  logic [CW:0]   cnt_inc;
  logic [CW-1:0] cnt_d;
  logic          dn_d, evt;
  logic          commit, commit_per;
  logic [CW-1:0] commit_val;

  pwm_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_i),
    .sel_i  (mode_q.pre),
    .tick_o (tick)
  );

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    evt   = 1'b0;
    if (!run_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (tick) begin
      if (!mode_q.center) begin
        dn_d = 1'b0;
        if (cnt_inc >= {1'b0, per_q}) begin
          cnt_d = '0;
          evt   = 1'b1;
        end else begin
          cnt_d = cnt_inc[CW-1:0];
        end
      end else if (per_q == '0) begin
        cnt_d = '0;
        evt   = 1'b1;
      end else if (dn_q || cnt_q >= per_q) begin
        if (cnt_q <= CW'(1)) begin
          cnt_d = '0;
          dn_d  = 1'b0;
          evt   = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
          dn_d  = 1'b1;
        end
      end else begin
        cnt_d = cnt_inc[CW-1:0];
      end
    end
  end

  // staged value lands at period end, at once when stopped
  always_comb begin
    commit     = 1'b0;
    commit_per = pend_per_q;
    commit_val = stage_q;
    if (stage_we_i && !run_i) begin
      commit     = 1'b1;
      commit_per = mode_q.stage_per;
      commit_val = wdata_i;
    end else if (pend_q && (evt || !run_i)) begin
      commit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= '0;
      duty_q     <= '0;
      per_q      <= '0;
      cnt_q      <= '0;
      dn_q       <= 1'b0;
      stage_q    <= '0;
      pend_q     <= 1'b0;
      pend_per_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
      if (mode_we_i) mode_q <= mode_i;
      if (stage_we_i && run_i) begin
        stage_q    <= wdata_i;
        pend_q     <= 1'b1;
        pend_per_q <= mode_q.stage_per;
      end else if (commit) begin
        pend_q <= 1'b0;
      end
      if (duty_we_i)                    duty_q <= wdata_i;
      else if (commit && !commit_per)   duty_q <= commit_val;
      if (per_we_i)                     per_q  <= wdata_i;
      else if (commit && commit_per)    per_q  <= commit_val;
    end
  end

  assign mode_o = mode_q;
  assign duty_o = duty_q;
  assign per_o  = per_q;
  assign cnt_o  = cnt_q;
  assign evt_o  = evt;
  assign pwm_o  = (run_i && (cnt_q < duty_q)) ^ mode_q.act_low;
endmodule

// File: rtl/pwm_irq.sv
module pwm_irq #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] evt_i,
  input  logic           mset_i,
  input  logic           mclr_i,
  input  logic [NCH-1:0] wdata_i,
  input  logic           flag_rd_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] mask_o,
  output logic           irq_o
);
  logic [NCH-1:0] flag_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= (flag_rd_i ? '0 : flag_q) | evt_i;
      if (mset_i)      mask_q <= mask_q | wdata_i;
      else if (mclr_i) mask_q <= mask_q & ~wdata_i;
    end
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_o  = |(flag_q & mask_q);
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] pwm_o,
  output logic           irq_o
);
  localparam int unsigned CHW = 4;

  logic           wr, rd, is_g, is_c;
  logic [CHW-1:0] ch_idx;
  logic [4:0]     off;
  logic [NCH-1:0] run_q, evt, flag, mask;
  logic [NCH*CW-1:0] duty_flat, per_flat, cnt_flat;
  ch_mode_t       mode [NCH];
  ch_mode_t       mode_w;
  logic [DW-1:0]  rd_val;
  logic           unused_bits;

  assign wr     = req_i & we_i;
  assign rd     = req_i & ~we_i;
  assign is_g   = (addr_i[AW-1:5] == '0);
  assign is_c   = (addr_i[AW-1:9] == (AW-9)'(1));
  assign ch_idx = addr_i[8:5];
  assign off    = addr_i[4:0];
  assign unused_bits = ^wdata_i[DW-1:CW];

  assign mode_w = '{stage_per: wdata_i[10], act_low: wdata_i[9],
                    center: wdata_i[8], pre: wdata_i[PRE_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (wr && is_g && off == G_START) run_q <= run_q | wdata_i[NCH-1:0];
    else if (wr && is_g && off == G_STOP)  run_q <= run_q & ~wdata_i[NCH-1:0];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic sel;
    assign sel = wr && is_c && (ch_idx == CHW'(n));
    pwm_channel #(.CW(CW)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q[n]),
      .mode_we_i  (sel && off == C_MODE),
      .mode_i     (mode_w),
      .duty_we_i  (sel && off == C_DUTY),
      .per_we_i   (sel && off == C_PER),
      .stage_we_i (sel && off == C_STAGE),
      .wdata_i    (wdata_i[CW-1:0]),
      .mode_o     (mode[n]),
      .duty_o     (duty_flat[n*CW +: CW]),
      .per_o      (per_flat[n*CW +: CW]),
      .cnt_o      (cnt_flat[n*CW +: CW]),
      .evt_o      (evt[n]),
      .pwm_o      (pwm_o[n])
    );
  end

  pwm_irq #(.NCH(NCH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .mset_i    (wr && is_g && off == G_MSET),
    .mclr_i    (wr && is_g && off == G_MCLR),
    .wdata_i   (wdata_i[NCH-1:0]),
    .flag_rd_i (rd && is_g && off == G_FLAG),
    .flag_o    (flag),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (is_g) begin
      case (off)
        G_STAT:  rd_val[NCH-1:0] = run_q;
        G_MASK:  rd_val[NCH-1:0] = mask;
        G_FLAG:  rd_val[NCH-1:0] = flag;
        default: ;
      endcase
    end else if (is_c) begin
      for (int n = 0; n < NCH; n++) begin
        if (ch_idx == CHW'(n)) begin
          case (off)
            C_MODE: begin
              rd_val[10]        = mode[n].stage_per;
              rd_val[9]         = mode[n].act_low;
              rd_val[8]         = mode[n].center;
              rd_val[PRE_W-1:0] = mode[n].pre;
            end
            C_DUTY:  rd_val[CW-1:0] = duty_flat[n*CW +: CW];
            C_PER:   rd_val[CW-1:0] = per_flat[n*CW +: CW];
            C_CNT:   rd_val[CW-1:0] = cnt_flat[n*CW +: CW];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 12,
  parameter int unsigned DW  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [NCH-1:0]    wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NCH-1:0]    run,
  input logic [NCH-1:0]    evt,
  input logic [NCH-1:0]    flag,
  input logic [NCH*CW-1:0] cnt_flat,
  input logic [NCH*CW-1:0] duty_flat
);
  localparam logic [AW-1:0] A_START = AW'(32'h04);
  localparam logic [AW-1:0] A_STOP  = AW'(32'h08);
  localparam logic [AW-1:0] A_STAT  = AW'(32'h0C);
  localparam logic [AW-1:0] A_FLAG  = AW'(32'h1C);

  AST_START_SETS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_START) |=> ((run & $past(wdata_i)) == $past(wdata_i))); // R1
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_STOP) |=> ((run & $past(wdata_i)) == '0)); // R2
  AST_STATUS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_STAT) |=> (rdata_o == DW'($past(run)))); // R3
  AST_FLAG_FROM_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag & ~$past(flag) & ~$past(evt)) == '0)); // R11
  AST_FLAG_READ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == A_FLAG) |=> ((flag & ~$past(evt)) == '0)); // R13

  for (genvar n = 0; n < NCH; n++) begin : g_a
    localparam logic [AW-1:0] A_DUTY = AW'(32'h200 + 32 * n + 4);
    AST_STOPPED_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(run[n]) |-> (cnt_flat[n*CW +: CW] == '0)); // R2
    AST_DUTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run[n]) && !$past(evt[n]) && !$past(req_i && we_i && addr_i == A_DUTY))
        |-> $stable(duty_flat[n*CW +: CW])); // R8
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i[NCH-1:0]),
  .rdata_o   (rdata_o),
  .run       (run_q),
  .evt       (evt),
  .flag      (flag),
  .cnt_flat  (cnt_flat),
  .duty_flat (duty_flat)
);

// File: tb/pwm_ctrl_tb_top.sv
module pwm_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .irq_o(irq)
  );

  function automatic logic [11:0] ca(int ch, int o);
    return 12'(32'h200 + 32 * ch + o);
  endfunction

  function automatic int exp_on(int p, int d, int c, bit ctr);
    int e;
    if (!ctr)        e = (d < p) ? d : p;
    else if (d == 0) e = 0;
    else if (d > p)  e = 2 * p;
    else             e = 2 * d - 1;
    return e << c;
  endfunction

  function automatic int win(int p, int c, bit ctr);
    return (ctr ? 2 * p : p) << c;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); d = rdata; req = 0;
  endtask

  task automatic count_on(int ch, int w, output int n);
    n = 0;
    repeat (w) begin @(negedge clk); if (pwm[ch]) n++; end
  endtask

  task automatic wave(string tag, int ch, int p, int d, int c, bit ctr, bit pol);
    int n, w, e;
    logic [31:0] v;
    wr(12'h008, 32'hF);
    wr(ca(ch, 0), (32'(pol) << 9) | (32'(ctr) << 8) | 32'(c));
    wr(ca(ch, 8), 32'(p));
    wr(ca(ch, 4), 32'(d));
    wr(12'h004, 32'(1) << ch);
    w = win(p, c, ctr);
    e = exp_on(p, d, c, ctr);
    repeat (w + 4) @(negedge clk);
    count_on(ch, w, n);
    chk(tag, 32'(n), pol ? 32'(w - e) : 32'(e));
    wr(12'h008, 32'(1) << ch);
    @(negedge clk);
    chk("R2/R7 idle level", 32'(pwm[ch]), 32'(pol));
    rd(ca(ch, 12), v);
    chk("R2 counter zero", v, 0);
    rd(12'h00C, v);
    chk("R3 status after stop", v[ch], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset outputs low", {27'b0, irq, pwm}, 0);
    rd(12'h00C, v); chk("R3 reset status", v, 0);
    rd(12'h018, v); chk("R12 reset mask", v, 0);

    // R1 / R3 group start and stop
    wr(12'h004, 32'h5); rd(12'h00C, v); chk("R1 start 0101", v, 32'h5);
    wr(12'h004, 32'h2); rd(12'h00C, v); chk("R1 zero bits keep", v, 32'h7);
    wr(12'h008, 32'h4); rd(12'h00C, v); chk("R2 stop one", v, 32'h3);
    wr(12'h008, 32'hF); rd(12'h00C, v); chk("R3 all stopped", v, 0);

    // R10 field widths
    wr(ca(3, 8), 32'hABCD_0123); rd(ca(3, 8), v); chk("R10 period width", v, 32'h0123);
    wr(ca(3, 4), 32'h5555_FEDC); rd(ca(3, 4), v); chk("R10 duty width", v, 32'hFEDC);
    wr(ca(3, 0), 32'hFFFF_FFFF); rd(ca(3, 0), v); chk("R10 mode fields", v, 32'h0000_070F);
    wr(ca(3, 0), 0);

    // R5 R6 R7 directed
    wave("R5 left p10 d3", 0, 10, 3, 0, 0, 0);
    wave("R5 left duty above period", 1, 12, 20, 0, 0, 0);
    wave("R6 center p8 d5", 2, 8, 5, 0, 1, 0);
    wave("R6 center duty 0", 3, 8, 0, 0, 1, 0);
    wave("R7 active low", 1, 16, 4, 0, 0, 1);
    wave("R4 prescale 10", 0, 3, 1, 10, 0, 0);
    wave("R4 prescale 11 clamps", 2, 3, 2, 11, 0, 0);

    // R4 R5 R6 R7 random
    for (int t = 0; t < 8; t++) begin
      int ch = int'($urandom % 4);
      int p  = 20 + int'($urandom % 60);
      int d  = int'($urandom % (p + 8));
      int c  = int'($urandom % 3);
      bit ct = 1'($urandom % 2);
      bit pl = 1'($urandom % 2);
      wave(ct ? "R6 random center" : "R5 random left", ch, p, d, c, ct, pl);
    end

    // R5 counter stays below period
    wr(ca(0, 0), 0); wr(ca(0, 8), 40); wr(12'h004, 1);
    for (int k = 0; k < 10; k++) begin
      repeat (int'($urandom % 37)) @(negedge clk);
      rd(ca(0, 12), v);
      chk("R5 counter below period", 32'(v < 40), 1);
    end
    wr(12'h008, 32'hF);

    // R8 staging while running
    wr(ca(2, 0), 0); wr(ca(2, 8), 100); wr(ca(2, 4), 10); wr(12'h004, 32'h4);
    repeat (3) @(negedge clk);
    wr(ca(2, 16), 70);
    rd(ca(2, 4), v); chk("R8 duty held before end", v, 10);
    repeat (120) @(negedge clk);
    rd(ca(2, 4), v); chk("R8 duty after end", v, 70);
    count_on(2, 100, n); chk("R8 new duty waveform", 32'(n), 70);
    wr(ca(2, 0), 32'h400); wr(ca(2, 16), 150);
    repeat (120) @(negedge clk);
    rd(ca(2, 8), v); chk("R8 period after end", v, 150);
    count_on(2, 150, n); chk("R8 new period waveform", 32'(n), 70);
    wr(12'h008, 32'h4);

    // R9 staging while stopped
    wr(ca(2, 0), 0); wr(ca(2, 16), 33);
    rd(ca(2, 4), v); chk("R9 stopped duty", v, 33);
    wr(ca(2, 0), 32'h400); wr(ca(2, 16), 77);
    rd(ca(2, 8), v); chk("R9 stopped period", v, 77);

    // R11 R12 R13 interrupts
    rd(12'h01C, v);
    wr(ca(1, 0), 0); wr(ca(1, 8), 300); wr(ca(1, 4), 5);
    wr(12'h010, 32'h2); wr(12'h004, 32'h2);
    repeat (320) @(negedge clk);
    chk("R11 irq on masked flag", 32'(irq), 1);
    rd(12'h01C, v); chk("R11 flag set", v, 32'h2);
    rd(12'h01C, v); chk("R13 flag cleared by read", v, 0);
    chk("R13 irq low after read", 32'(irq), 0);
    rd(12'h018, v); chk("R12 mask read", v, 32'h2);
    wr(12'h014, 32'h2);
    rd(12'h018, v); chk("R12 mask cleared", v, 0);
    repeat (320) @(negedge clk);
    chk("R12 irq off when masked", 32'(irq), 0);
    rd(12'h01C, v); chk("R11 flag without mask", v, 32'h2);
    wr(12'h008, 32'hF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule